// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running watchdog timer with a small word-addressed register file. A slow tick strobe feeds a power-of-two prescaler. Each prescaler period moves a 12-bit down-counter one step. Software controls the timer only through magic values written to a key register. One key starts the timer, one refreshes the count, and one opens the configuration registers for writing. Any other key value closes them again. Once started, the timer cannot be halted short of a system reset.

The prescaler and reload settings do not take effect at once. Each accepted write holds a per-register pending flag for a fixed number of ticks, which models a crossing into the counter's clock domain. The new value applies when the flag drops. When a decrement step finds the counter at zero, the block emits a one-cycle reset request and reloads the counter. An optional early-warning interrupt is raised when the count steps onto a programmed compare value. It stays high until software writes the acknowledge bit. The acknowledge is accepted whether or not the registers are unlocked.

The register offsets are: key 0x00, divider 0x04, reload 0x08, status 0x0C, window 0x10 and early control 0x14. The window register is plain storage here and has no effect on the count.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, the registers are locked and the timer is idle. The divider reads 0, reload reads 0xFFF, status reads 0 and early control reads 0. Both outputs are low, and no reset request appears until the timer is started.
- R2: Writing 0x5555 to the key register unlocks writes to the divider, reload, window and early-control fields. Any other key value, including 0x0000, locks them. A write to a locked register changes neither its readback value nor the status flags.
- R3: Writing 0xCCCC to the key register starts the timer with the count loaded from the reload value. When the tick is high every cycle, with divisor D and reload R, `wdog_rst_o` is high for exactly one cycle, D*(R+1) cycles after the start-key write edge. The pattern then repeats every D*(R+1) cycles. Later key writes of any value do not stop it.
- R4: Writing 0xAAAA to the key register reloads the count and restarts the prescaler phase, so the next reset request comes D*(R+1) cycles after that write. A refresh that lands on the same edge as the expiring step wins, and no reset request is produced.
- R5: Divider bits 3:0 hold an encoding n that selects divide-by 2^(n+2). An encoding above 8 is stored and read back as 8, which is divide-by 1024.
- R6: The reload value occupies bits 11:0 of its register. Upper written bits are dropped.
- R7: An accepted divider write sets status bit 0, and an accepted reload write sets status bit 1. Each flag stays set for 3 tick cycles after the write edge, then clears, and the new value takes effect at that point.
- R8: In early control, bits 11:0 hold the compare value and bit 15 enables the interrupt. With the enable set, `early_irq_o` rises on the edge where a decrement step brings the count to the compare value. It stays high until acknowledged.
- R9: Writing 1 to early-control bit 14 clears a pending early interrupt, even while the registers are locked. A locked acknowledge leaves the compare value and enable bit unchanged.
- R10: The prescaler advances only on cycles where `tick_i` is high. Cycles with the tick low delay the reset request by the same number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Slow tick strobe that feeds the prescaler and update delay |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| wdog_rst_o | output | 1 | One-cycle reset request on expiry |
| early_irq_o | output | 1 | Early-warning interrupt, held until acknowledged |

## Verification
A refresh key write and the decrement step that would find the counter at zero can fall on the same clock edge. The bench provokes this by timing a refresh write so it is captured exactly on the expiry edge. The reset request it had queued for that cycle is withdrawn, and a new one is expected a full period after the refresh; any pulse on the contested cycle is reported. A locked acknowledge is also issued while the early interrupt is pending. The bench judges it by the interrupt dropping and then rising again one full period later with the same compare value.

// File: rtl/kwd_pkg.sv
// Package for the keyed watchdog.
// Holds the bus widths, the key codes and the register selector values
// decoded from bus address bits 4:2.
package kwd_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;

    localparam logic [2:0] SEL_KEY    = 3'd0;
    localparam logic [2:0] SEL_DIV    = 3'd1;
    localparam logic [2:0] SEL_RELOAD = 3'd2;
    localparam logic [2:0] SEL_STATUS = 3'd3;
    localparam logic [2:0] SEL_WINDOW = 3'd4;
    localparam logic [2:0] SEL_EARLY  = 3'd5;

    localparam int EARLY_ACK_BIT = 14;
    localparam int EARLY_EN_BIT  = 15;
endpackage

// File: rtl/kwd_pending.sv
// Staged configuration register.
// A load captures data into the shadow copy and starts a wait of
// SYNC_TICKS ticks. While the wait runs, busy_o is high. When the wait
// ends, the shadow is copied to the active output.
// Assumes: load_i is a single-cycle strobe. A load during a wait restarts it.
module kwd_pending #(
    parameter int         W          = 12,
    parameter int         SYNC_TICKS = 3,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] shadow_o,
    output logic [W-1:0] active_o,
    output logic         busy_o
);
    localparam int SC_W = $clog2(SYNC_TICKS + 1);

    logic [SC_W-1:0] wait_q;

    // Capture on load, count ticks down, then apply the shadow value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_o <= RST_VAL;
            active_o <= RST_VAL;
            wait_q   <= '0;
        end else if (load_i) begin
            shadow_o <= data_i;
            wait_q   <= SC_W'(SYNC_TICKS);
        end else if (tick_i && (wait_q != '0)) begin
            wait_q <= wait_q - 1'b1;
            if (wait_q == SC_W'(1)) begin
                active_o <= shadow_o;
            end
        end
    end

    assign busy_o = (wait_q != '0);
endmodule

// File: rtl/kwd_regs.sv
// Register file and key decoder.
// Decodes word-aligned byte addresses. Handles the lock and unlock keys,
// the start latch and the refresh strobe. Holds the early-control and
// window fields. Stages the divider and reload values through kwd_pending.
// Reads are combinational.
// Assumes: one write strobe per cycle. Unmapped or unaligned addresses
// read as zero and ignore writes.
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int PR_W       = 4,
    parameter int PR_MAX     = 8,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              running_o,
    output logic              load_cnt_o,
    output logic [PR_W-1:0]   div_sel_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              early_en_o,
    output logic              ack_o
);
    localparam logic [PR_W-1:0] PR_CAP = PR_W'(PR_MAX);

    logic [2:0]       sel;
    logic             aligned;
    logic             key_wr;
    logic             cfg_wr;
    logic             unlocked_q;
    logic             running_q;
    logic [CNT_W-1:0] window_q;
    logic [CNT_W-1:0] cmp_q;
    logic             en_q;
    logic [PR_W-1:0]  div_in;
    logic [PR_W-1:0]  div_shadow;
    logic [CNT_W-1:0] reload_shadow;
    logic             div_busy;
    logic             reload_busy;

    // Address decode and write qualification.
    assign sel     = addr_i[4:2];
    assign aligned = (addr_i[1:0] == 2'b00);
    assign key_wr  = wr_i && aligned && (sel == SEL_KEY);
    assign cfg_wr  = wr_i && aligned && unlocked_q;

    // Clamp the divider encoding to the largest supported setting.
    assign div_in = (wdata_i[PR_W-1:0] > PR_CAP) ? PR_CAP : wdata_i[PR_W-1:0];

    // Lock state follows the most recent key write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q <= 1'b0;
        end else if (key_wr) begin
            unlocked_q <= (wdata_i == KEY_UNLOCK);
        end
    end

    // Start latch: once set, only reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
        end else if (key_wr && (wdata_i == KEY_START)) begin
            running_q <= 1'b1;
        end
    end

    // Unstaged configuration fields: window storage and early control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= '1;
            cmp_q    <= '0;
            en_q     <= 1'b0;
        end else if (cfg_wr) begin
            if (sel == SEL_WINDOW) begin
                window_q <= wdata_i[CNT_W-1:0];
            end
            if (sel == SEL_EARLY) begin
                cmp_q <= wdata_i[CNT_W-1:0];
                en_q  <= wdata_i[EARLY_EN_BIT];
            end
        end
    end

    kwd_pending #(
        .W          (PR_W),
        .SYNC_TICKS (SYNC_TICKS),
        .RST_VAL    ('0)
    ) u_div_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .load_i   (cfg_wr && (sel == SEL_DIV)),
        .data_i   (div_in),
        .shadow_o (div_shadow),
        .active_o (div_sel_o),
        .busy_o   (div_busy)
    );

    kwd_pending #(
        .W          (CNT_W),
        .SYNC_TICKS (SYNC_TICKS),
        .RST_VAL    ('1)
    ) u_reload_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .load_i   (cfg_wr && (sel == SEL_RELOAD)),
        .data_i   (wdata_i[CNT_W-1:0]),
        .shadow_o (reload_shadow),
        .active_o (reload_o),
        .busy_o   (reload_busy)
    );

    // Strobes toward the counter and the interrupt flag.
    assign load_cnt_o = key_wr && ((wdata_i == KEY_REFRESH) || (wdata_i == KEY_START));
    assign ack_o      = wr_i && aligned && (sel == SEL_EARLY) && wdata_i[EARLY_ACK_BIT];
    assign running_o  = running_q;
    assign cmp_o      = cmp_q;
    assign early_en_o = en_q;

    // Read-back multiplexer.
    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (sel)
                SEL_DIV:    rdata_o = {{(DATA_W-PR_W){1'b0}}, div_shadow};
                SEL_RELOAD: rdata_o = {{(DATA_W-CNT_W){1'b0}}, reload_shadow};
                SEL_STATUS: rdata_o = {{(DATA_W-2){1'b0}}, reload_busy, div_busy};
                SEL_WINDOW: rdata_o = {{(DATA_W-CNT_W){1'b0}}, window_q};
                SEL_EARLY:  rdata_o = {en_q, 1'b0, {(DATA_W-2-CNT_W){1'b0}}, cmp_q};
                default:    rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/kwd_prescaler.sv
// Power-of-two tick divider.
// While running, counts tick cycles and emits step_o on the tick that
// completes a period of 2^(div_sel_i+2) ticks.
// Assumes: restart_i realigns the phase to zero and overrides counting.
module kwd_prescaler #(
    parameter int PR_W   = 4,
    parameter int PR_MAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            run_i,
    input  logic            restart_i,
    input  logic [PR_W-1:0] div_sel_i,
    output logic            step_o
);
    localparam int PC_W = PR_MAX + 2;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] lim;

    // Terminal count: the low (div_sel_i + 2) bits set.
    always_comb begin
        lim = '0;
        for (int i = 0; i < PC_W; i++) begin
            if (i < int'(div_sel_i) + 2) begin
                lim[i] = 1'b1;
            end
        end
    end

    assign step_o = run_i && tick_i && (pc_q >= lim);

    // Phase counter: restart, wrap on a step, otherwise count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (restart_i) begin
            pc_q <= '0;
        end else if (run_i && tick_i) begin
            pc_q <= step_o ? '0 : pc_q + 1'b1;
        end
    end
endmodule

// File: rtl/kwd_counter.sv
// Down-counter with expiry pulse and early-warning flag.
// A load sets the count to the reload value. A step decrements it, or,
// at zero, reloads it and raises a one-cycle expiry. The early flag sets
// when a step lands on the compare value with the enable on. It clears
// on acknowledge, and a same-cycle set wins over the acknowledge.
// Assumes: load has priority over a coincident step.
module kwd_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             early_en_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o,
    output logic             irq_o
);
    logic             at_zero;
    logic [CNT_W-1:0] dec;
    logic             hit;

    assign at_zero = (cnt_o == '0);
    assign dec     = cnt_o - 1'b1;
    assign hit     = step_i && !load_i && early_en_i && !at_zero && (dec == cmp_i);

    // Count register and expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= '1;
            expire_o <= 1'b0;
        end else begin
            expire_o <= step_i && at_zero && !load_i;
            if (load_i) begin
                cnt_o <= reload_i;
            end else if (step_i) begin
                cnt_o <= at_zero ? reload_i : dec;
            end
        end
    end

    // Early-warning flag: set on a hit, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (hit) begin
            irq_o <= 1'b1;
        end else if (ack_i) begin
            irq_o <= 1'b0;
        end
    end
endmodule

// File: rtl/keyed_wdog.sv
// Top of the keyed watchdog.
// Connects the register file, the prescaler and the down-counter.
// Assumes: a single clock. The tick strobe is synchronous to clk.
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int PR_W       = 4,
    parameter int PR_MAX     = 8,
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              wdog_rst_o,
    output logic              early_irq_o
);
    logic             running;
    logic             load_cnt;
    logic [PR_W-1:0]  div_sel;
    logic [CNT_W-1:0] reload_act;
    logic [CNT_W-1:0] cmp;
    logic             early_en;
    logic             ack;
    logic             step;
    logic [CNT_W-1:0] cnt;

    kwd_regs #(
        .CNT_W      (CNT_W),
        .PR_W       (PR_W),
        .PR_MAX     (PR_MAX),
        .SYNC_TICKS (SYNC_TICKS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .running_o  (running),
        .load_cnt_o (load_cnt),
        .div_sel_o  (div_sel),
        .reload_o   (reload_act),
        .cmp_o      (cmp),
        .early_en_o (early_en),
        .ack_o      (ack)
    );

    kwd_prescaler #(
        .PR_W   (PR_W),
        .PR_MAX (PR_MAX)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .run_i     (running),
        .restart_i (load_cnt),
        .div_sel_i (div_sel),
        .step_o    (step)
    );

    kwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_i     (load_cnt),
        .reload_i   (reload_act),
        .cmp_i      (cmp),
        .early_en_i (early_en),
        .ack_i      (ack),
        .cnt_o      (cnt),
        .expire_o   (wdog_rst_o),
        .irq_o      (early_irq_o)
    );
endmodule

// File: rtl/kwd_checker.sv
// Protocol checker for keyed_wdog, attached by bind.
// Watches the nets between the register file, prescaler and counter.
module kwd_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             step,
    input logic             load_cnt,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload_act,
    input logic             ack,
    input logic             wdog_rst_o,
    input logic             early_irq_o
);
    AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |=> !wdog_rst_o);                                                       // R3
    AST_RST_FROM_ZERO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst_o |-> ($past(step) && ($past(cnt) == '0) && !$past(load_cnt)));          // R4
    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !step);                                                               // R3
    AST_STEP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_cnt && (cnt != '0)) |=> (cnt == $past(cnt) - 1'b1));               // R3
    AST_REFRESH_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load_cnt |=> (cnt == $past(reload_act)));                                          // R4
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (early_irq_o && !ack) |=> early_irq_o);                                            // R8
endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .step        (step),
    .load_cnt    (load_cnt),
    .cnt         (cnt),
    .reload_act  (reload_act),
    .ack         (ack),
    .wdog_rst_o  (wdog_rst_o),
    .early_irq_o (early_irq_o)
);

// File: tb/keyed_wdog_tb.sv
// Scoreboard bench for keyed_wdog.
// Driver tasks queue the expected cycles of reset requests and interrupt
// rises. A negedge monitor pops and compares them as they appear.
module keyed_wdog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        wdog_rst;
    logic        early_irq;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int exp_rst[$];
    int exp_irq[$];
    int e_tmp;
    logic irq_prev = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    keyed_wdog u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_en),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .wdog_rst_o  (wdog_rst),
        .early_irq_o (early_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Monitor: compare observed events with the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wdog_rst) begin
                if (exp_rst.size() == 0) begin
                    check(1'b0, "R3 unexpected reset request", cyc, -1);
                end else begin
                    e_tmp = exp_rst.pop_front();
                    check(cyc == e_tmp, "R3/R4 reset request cycle", cyc, e_tmp);
                end
            end
            if (early_irq && !irq_prev) begin
                if (exp_irq.size() == 0) begin
                    check(1'b0, "R8 unexpected interrupt", cyc, -1);
                end else begin
                    e_tmp = exp_irq.pop_front();
                    check(cyc == e_tmp, "R8 interrupt rise cycle", cyc, e_tmp);
                end
            end
        end
        irq_prev = rst_n ? early_irq : 1'b0;
    end

    task automatic do_reset();
        rst_n = 1'b0;
        exp_rst.delete();
        exp_irq.delete();
        tick_en = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, output int t);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        t = cyc;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic cfg(input logic [15:0] pr, input logic [15:0] rl);
        int t;
        wr(5'h00, 16'h5555, t);
        wr(5'h04, pr, t);
        wr(5'h08, rl, t);
        wr(5'h00, 16'h0000, t);
        repeat (4) @(negedge clk);
    endtask

    task automatic queues_empty(input string req);
        check(exp_rst.size() == 0, req, exp_rst.size(), 0);
        check(exp_irq.size() == 0, req, exp_irq.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc, 200000);
        finish_run();
    end

    initial begin
        int t, t1, t2;
        logic [15:0] d;

        do_reset();

        // R1: reset state.
        rd(5'h04, d); check(d == 16'h0000, "R1 divider reset", d, 16'h0000);
        rd(5'h08, d); check(d == 16'h0FFF, "R1 reload reset", d, 16'h0FFF);
        rd(5'h0C, d); check(d == 16'h0000, "R1 status reset", d, 16'h0000);
        rd(5'h14, d); check(d == 16'h0000, "R1 early reset", d, 16'h0000);
        check(!wdog_rst && !early_irq, "R1 outputs low", {wdog_rst, early_irq}, 0);
        repeat (40) @(negedge clk);
        queues_empty("R1 idle without start");

        // R2: locked writes ignored.
        wr(5'h08, 16'h0005, t);
        rd(5'h0C, d); check(d == 16'h0000, "R2 locked write no pending", d, 0);
        rd(5'h08, d); check(d == 16'h0FFF, "R2 locked reload kept", d, 16'h0FFF);
        // R7 and R6: unlocked write, pending window, 12-bit field.
        wr(5'h00, 16'h5555, t);
        wr(5'h08, 16'hF005, t);
        rd(5'h0C, d); check(d == 16'h0002, "R7 reload pending set", d, 2);
        rd(5'h08, d); check(d == 16'h0005, "R6 reload masked to 12 bits", d, 5);
        wait_to(t + 2);
        rd(5'h0C, d); check(d == 16'h0002, "R7 reload pending held", d, 2);
        wait_to(t + 3);
        rd(5'h0C, d); check(d == 16'h0000, "R7 reload pending cleared", d, 0);
        // R5: clamp and divider pending flag.
        wr(5'h04, 16'h000C, t);
        rd(5'h0C, d); check(d == 16'h0001, "R7 divider pending set", d, 1);
        rd(5'h04, d); check(d == 16'h0008, "R5 divider clamped", d, 8);
        // R2: relock by 0x0000 and by an arbitrary key.
        wr(5'h00, 16'h0000, t);
        wr(5'h08, 16'h0007, t);
        rd(5'h08, d); check(d == 16'h0005, "R2 relock by zero key", d, 5);
        wr(5'h00, 16'h5555, t);
        wr(5'h00, 16'h1234, t);
        wr(5'h14, 16'h8003, t);
        rd(5'h14, d); check(d == 16'h0000, "R2 relock by other key", d, 0);

        // R3: periodic expiry, not stopped by later keys.
        do_reset();
        cfg(16'h0000, 16'h0003);
        wr(5'h00, 16'hCCCC, t);
        exp_rst.push_back(t + 16);
        exp_rst.push_back(t + 32);
        wait_to(t + 5);
        wr(5'h00, 16'h0000, t1);
        wait_to(t + 40);
        queues_empty("R3 expiry sequence");

        // R5: divide-by-8 and clamped divide-by-1024.
        do_reset();
        cfg(16'h0001, 16'h0002);
        wr(5'h00, 16'hCCCC, t);
        exp_rst.push_back(t + 24);
        wait_to(t + 30);
        queues_empty("R5 divide by 8");
        do_reset();
        cfg(16'h000C, 16'h0000);
        wr(5'h00, 16'hCCCC, t);
        exp_rst.push_back(t + 1024);
        wait_to(t + 1030);
        queues_empty("R5 divide by 1024");

        // R4: refresh, then refresh on the expiry edge.
        do_reset();
        cfg(16'h0000, 16'h0003);
        wr(5'h00, 16'hCCCC, t);
        exp_rst.push_back(t + 16);
        wait_to(t + 10);
        wr(5'h00, 16'hAAAA, t1);
        exp_rst.delete();
        exp_rst.push_back(t1 + 16);
        wait_to(t1 + 15);
        wr(5'h00, 16'hAAAA, t2);
        check(t2 == t1 + 16, "R4 refresh placed on expiry edge", t2, t1 + 16);
        exp_rst.delete();
        exp_rst.push_back(t2 + 16);
        wait_to(t2 + 20);
        queues_empty("R4 refresh wins");

        // R8 and R9: early interrupt, locked acknowledge.
        do_reset();
        wr(5'h00, 16'h5555, t);
        wr(5'h14, 16'h8004, t);
        cfg(16'h0000, 16'h000A);
        wr(5'h00, 16'hCCCC, t);
        exp_irq.push_back(t + 24);
        exp_rst.push_back(t + 44);
        wait_to(t + 30);
        check(early_irq == 1'b1, "R8 interrupt held", early_irq, 1);
        wr(5'h14, 16'h4000, t1);
        check(early_irq == 1'b0, "R9 locked acknowledge clears", early_irq, 0);
        exp_irq.push_back(t + 68);
        exp_rst.push_back(t + 88);
        rd(5'h14, d); check(d == 16'h8004, "R9 fields kept after ack", d, 16'h8004);
        wait_to(t + 92);
        queues_empty("R8 R9 interrupt sequence");

        // R10: tick gating delays the count.
        do_reset();
        cfg(16'h0000, 16'h0001);
        wr(5'h00, 16'hCCCC, t);
        tick_en = 1'b0;
        exp_rst.push_back(t + 13);
        wait_to(t + 5);
        tick_en = 1'b1;
        wait_to(t + 16);
        queues_empty("R10 tick gating");

        finish_run();
    end
endmodule